// File: doc/BRIEF.md
# Debug Exception Stop Controller

This block sits beside a processor core and decides, exception by exception, whether control passes to an attached debugger. Software programs a per-class stop mask. When the core reports an exception, the block records in a sticky cause register whether that class was armed to stop. If it was, the block raises the CPU stall output. An external stall request from the debugger sets or releases the stall on its edges. A control bit disables the debugger and forces the stall low.

The block also holds one injected instruction word written by the debugger. The word is handed to the core as soon as the core is halted and out of reset. A word written while the core runs waits and goes out on the cycle the stall is raised. While single-step mode is on, a break exception is flagged so the core can ignore it. The injected word leaves on a valid/data pair with no ready signal. The core must take the word in the one cycle that valid is high, and the block never holds the word waiting for acceptance.

Register map (2-bit address): 0 is the stop mask, bits [13:0]. 1 is the cause record, bits [13:0]. 2 is control: bit 0 is single-step and bit 1 is debugger-disable. 3 is the injection register, which can be written but not read. Exception class codes are 0 reset, 1 bus error, 2 data page fault, 3 instruction page fault, 4 low-priority interrupt, 5 alignment, 6 illegal instruction, 7 high-priority interrupt, 8 data TLB miss, 9 instruction TLB miss, 10 range, 11 system call, 12 break and 13 trap. Codes 14 and 15 are not exceptions.

Top module: `dbgstop_ctrl`

## Requirements
- R1: After reset, cpu_stall, inj_valid and rd_err are 0, and the stop mask, cause record and control register read as 0.
- R2: An exception strobe with class code c in 0..13 loads cause bit c with stop mask bit c on the next edge, and leaves the other cause bits unchanged. Codes 14 and 15 change nothing.
- R3: An exception whose class has its stop mask bit set raises cpu_stall from the next edge, unless debugger-disable is set.
- R4: A rising edge on ext_stall_req sets cpu_stall from the next edge and a falling edge clears it. Otherwise the stall holds. An armed exception in the same cycle as a falling edge leaves the stall set.
- R5: Writing control bit 1 as 1 forces cpu_stall to 0 from the next edge. The stall stays 0 while the bit is set, even for armed exceptions and request edges.
- R6: exc_ignore is high in the same cycle as an exception strobe with class 12 (break) while control bit 0 (single-step) is set. It is low otherwise.
- R7: A write to address 3 while cpu_stall is 1 and core_in_reset is 0 produces inj_valid for one cycle after the write edge, with inj_data equal to the written word, and leaves nothing pending.
- R8: A word written to address 3 while the core is not stalled, or is in reset, is held pending. It is issued on inj_valid in the first cycle cpu_stall reads 1 after a rise of the stall, and is not issued again on a later rise.
- R9: A read of address 3 raises rd_err and returns 0. Reads of addresses 0 to 2 return the register contents with rd_err low.
- R10: A software write to the cause record loads it. An exception in the same cycle overrides that class's bit with its stop mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational |
| cfg_err | output | 1 | Read access error |
| exc_valid | input | 1 | Exception strobe from the core |
| exc_class | input | 4 | Encoded exception class |
| ext_stall_req | input | 1 | Debugger stall request level, edge-acted |
| core_in_reset | input | 1 | Core is held in reset |
| cpu_stall | output | 1 | Stall to the core |
| stop_reason | output | 14 | Sticky cause record |
| exc_ignore | output | 1 | Core should ignore this exception |
| inj_valid | output | 1 | Injected instruction issued this cycle |
| inj_data | output | 32 | Injected instruction word |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a software write of the cause record and an exception strobe. The bench drives both strobes on one edge and expects the exception's class bit to win over the written data. The second pair is a write to the injection register and a stall change. The bench writes a word while running and then raises the stall. It also writes a word while halted in reset and then cycles the stall. In each case it judges the cycle of the valid pulse, the data carried, and the absence of a second pulse on a later rise.

// File: rtl/dbgstop_pkg.sv
package dbgstop_pkg;
  typedef enum logic [1:0] {
    A_STOPMASK = 2'd0,
    A_CAUSE    = 2'd1,
    A_CTRL     = 2'd2,
    A_INJECT   = 2'd3
  } reg_addr_e;

  localparam int CTRL_STEP_BIT = 0;
  localparam int CTRL_DIS_BIT  = 1;
endpackage

// File: rtl/dbgstop_regs.sv
module dbgstop_regs
  import dbgstop_pkg::*;
#(
  parameter int NUM_CLASS   = 14,
  parameter int CLS_W       = 4,
  parameter int DATA_W      = 32,
  parameter int BREAK_CLASS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  reg_addr_e            wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_en,
  input  reg_addr_e            rd_addr,
  input  logic                 exc_valid,
  input  logic [CLS_W-1:0]     exc_class,
  output logic [NUM_CLASS-1:0] stop_mask,
  output logic [NUM_CLASS-1:0] cause,
  output logic                 dis_q,
  output logic                 dis_nxt,
  output logic                 exc_hit,
  output logic                 exc_ignore,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_err
);
  logic                 step_q;
  logic [NUM_CLASS-1:0] hit_vec;
  logic [NUM_CLASS-1:0] cause_nxt;
  logic                 wr_cause;

  assign wr_cause = wr_en && (wr_addr == A_CAUSE);

  for (genvar i = 0; i < NUM_CLASS; i++) begin : g_class
    always_comb begin
      hit_vec[i]   = exc_valid && (exc_class == CLS_W'(i));
      cause_nxt[i] = hit_vec[i] ? stop_mask[i]
                   : (wr_cause ? wr_data[i] : cause[i]);
    end
  end

  assign exc_hit    = |(hit_vec & stop_mask);
  assign exc_ignore = exc_valid && (exc_class == CLS_W'(BREAK_CLASS)) && step_q;
  assign dis_nxt    = (wr_en && wr_addr == A_CTRL) ? wr_data[CTRL_DIS_BIT] : dis_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_mask <= '0;
      cause     <= '0;
      step_q    <= 1'b0;
      dis_q     <= 1'b0;
    end else begin
      cause <= cause_nxt;
      dis_q <= dis_nxt;
      if (wr_en && wr_addr == A_STOPMASK) stop_mask <= wr_data[NUM_CLASS-1:0];
      if (wr_en && wr_addr == A_CTRL)     step_q    <= wr_data[CTRL_STEP_BIT];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_err  = 1'b0;
    if (rd_en) begin
      case (rd_addr)
        A_STOPMASK: rd_data = DATA_W'(stop_mask);
        A_CAUSE:    rd_data = DATA_W'(cause);
        A_CTRL:     rd_data = DATA_W'({dis_q, step_q});
        default:    rd_err  = 1'b1;
      endcase
    end
  end

  // R2: cause bit of the reported class takes the mask bit
  p_cause_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && (exc_class < CLS_W'(NUM_CLASS))
      |=> cause[$past(exc_class)] == $past(stop_mask[exc_class]));

  // R2: codes outside the class range leave the record alone
  p_cause_bad_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && (exc_class >= CLS_W'(NUM_CLASS)) && !wr_cause |=> $stable(cause));

  // R9: an errored read carries no data
  p_rd_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_data == '0) && rd_en);
endmodule

// File: rtl/dbgstop_stall.sv
module dbgstop_stall (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_q,
  input  logic dis_nxt,
  input  logic exc_hit,
  input  logic ext_req,
  output logic stall_q,
  output logic stall_rise
);
  logic ext_q;
  logic ext_rise;
  logic ext_fall;
  logic stall_nxt;

  assign ext_rise = ext_req && !ext_q;
  assign ext_fall = !ext_req && ext_q;

  always_comb begin
    if (dis_nxt)       stall_nxt = 1'b0;
    else if (exc_hit)  stall_nxt = 1'b1;
    else if (ext_rise) stall_nxt = 1'b1;
    else if (ext_fall) stall_nxt = 1'b0;
    else               stall_nxt = stall_q;
  end

  assign stall_rise = stall_nxt && !stall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q   <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      ext_q   <= ext_req;
      stall_q <= stall_nxt;
    end
  end

  // R5: disable holds the stall low
  p_disable_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> !stall_q);

  // R3: an armed exception stalls unless disabled
  p_exc_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_hit |=> stall_q || dis_q);

  // R4: request fall releases the stall when nothing else intervenes
  p_ext_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fall && !exc_hit |=> !stall_q);
endmodule

// File: rtl/dbgstop_inject.sv
module dbgstop_inject #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_inj,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stall_q,
  input  logic              stall_rise,
  input  logic              core_in_reset,
  output logic              inj_valid,
  output logic [DATA_W-1:0] inj_data
);
  logic              pend_q;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_nxt;
  logic              issue;

  assign word_nxt = wr_inj ? wr_data : word_q;
  assign issue    = (wr_inj && stall_q && !core_in_reset)
                 || (stall_rise && (pend_q || wr_inj));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      word_q    <= '0;
      inj_valid <= 1'b0;
      inj_data  <= '0;
    end else begin
      word_q    <= word_nxt;
      inj_valid <= issue;
      if (issue)       pend_q <= 1'b0;
      else if (wr_inj) pend_q <= 1'b1;
      if (issue)       inj_data <= word_nxt;
    end
  end

  // R7: a write into a halted, running-out-of-reset core goes out next cycle
  p_issue_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inj && stall_q && !core_in_reset |=> inj_valid && (inj_data == $past(wr_data)));

  // R8: a pending word goes out as the stall rises
  p_issue_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_rise && pend_q |=> inj_valid && stall_q);
endmodule

// File: rtl/dbgstop_ctrl.sv
module dbgstop_ctrl
  import dbgstop_pkg::*;
#(
  parameter int NUM_CLASS   = 14,
  parameter int CLS_W       = 4,
  parameter int DATA_W      = 32,
  parameter int BREAK_CLASS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [1:0]           cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  output logic                 cfg_err,
  input  logic                 exc_valid,
  input  logic [CLS_W-1:0]     exc_class,
  input  logic                 ext_stall_req,
  input  logic                 core_in_reset,
  output logic                 cpu_stall,
  output logic [NUM_CLASS-1:0] stop_reason,
  output logic                 exc_ignore,
  output logic                 inj_valid,
  output logic [DATA_W-1:0]    inj_data
);
  reg_addr_e            addr_e;
  logic [NUM_CLASS-1:0] stop_mask;
  logic                 dis_q;
  logic                 dis_nxt;
  logic                 exc_hit;
  logic                 stall_rise;
  logic                 wr_inj;

  assign addr_e = reg_addr_e'(cfg_addr);
  assign wr_inj = cfg_wr && (addr_e == A_INJECT);

  dbgstop_regs #(
    .NUM_CLASS(NUM_CLASS), .CLS_W(CLS_W), .DATA_W(DATA_W), .BREAK_CLASS(BREAK_CLASS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr), .wr_addr(addr_e), .wr_data(cfg_wdata),
    .rd_en(cfg_rd), .rd_addr(addr_e),
    .exc_valid(exc_valid), .exc_class(exc_class),
    .stop_mask(stop_mask), .cause(stop_reason),
    .dis_q(dis_q), .dis_nxt(dis_nxt), .exc_hit(exc_hit), .exc_ignore(exc_ignore),
    .rd_data(cfg_rdata), .rd_err(cfg_err)
  );

  dbgstop_stall u_stall (
    .clk(clk), .rst_n(rst_n),
    .dis_q(dis_q), .dis_nxt(dis_nxt), .exc_hit(exc_hit), .ext_req(ext_stall_req),
    .stall_q(cpu_stall), .stall_rise(stall_rise)
  );

  dbgstop_inject #(.DATA_W(DATA_W)) u_inject (
    .clk(clk), .rst_n(rst_n),
    .wr_inj(wr_inj), .wr_data(cfg_wdata),
    .stall_q(cpu_stall), .stall_rise(stall_rise), .core_in_reset(core_in_reset),
    .inj_valid(inj_valid), .inj_data(inj_data)
  );

  // R6: ignore flag only accompanies a strobe
  p_ignore_needs_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ignore |-> exc_valid);
endmodule

// File: tb/dbgstop_ctrl_bench.sv
module dbgstop_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_err;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_class = '0;
  logic        ext_stall_req = 1'b0;
  logic        core_in_reset = 1'b0;
  logic        cpu_stall;
  logic [13:0] stop_reason;
  logic        exc_ignore;
  logic        inj_valid;
  logic [31:0] inj_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dbgstop_ctrl u_dbgstop_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .exc_valid(exc_valid), .exc_class(exc_class), .ext_stall_req(ext_stall_req),
    .core_in_reset(core_in_reset), .cpu_stall(cpu_stall), .stop_reason(stop_reason),
    .exc_ignore(exc_ignore), .inj_valid(inj_valid), .inj_data(inj_data)
  );

  // {mask[13:0], class[3:0], expected cause[13:0], expected stall}
  localparam logic [32:0] VEC [10] = '{
    {14'h3FFF, 4'd0,  14'h0001, 1'b1},
    {14'h0000, 4'd5,  14'h0000, 1'b0},
    {14'h1000, 4'd12, 14'h1000, 1'b1},
    {14'h1000, 4'd13, 14'h0000, 1'b0},
    {14'h2000, 4'd13, 14'h2000, 1'b1},
    {14'h3FFF, 4'd14, 14'h0000, 1'b0},
    {14'h0080, 4'd7,  14'h0080, 1'b1},
    {14'h3F7F, 4'd7,  14'h0000, 1'b0},
    {14'h0400, 4'd10, 14'h0400, 1'b1},
    {14'h3FFF, 4'd15, 14'h0000, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic exc(input logic [3:0] c);
    exc_valid = 1'b1; exc_class = c;
    @(negedge clk);
    exc_valid = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a,
                          input logic [31:0] exp_d, input logic exp_e);
    cfg_rd = 1'b1; cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp_d);
    check(req, {31'd0, cfg_err}, {31'd0, exp_e});
    cfg_rd = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    // R1: reset state
    check("R1 stall", {31'd0, cpu_stall}, 32'd0);
    check("R1 inj_valid", {31'd0, inj_valid}, 32'd0);
    rd_check("R1 mask", 2'd0, 32'd0, 1'b0);
    rd_check("R1 cause", 2'd1, 32'd0, 1'b0);
    rd_check("R1 ctrl", 2'd2, 32'd0, 1'b0);

    // Table: R2 cause loading and R3 stall per class
    for (int i = 0; i < 10; i++) begin
      logic [32:0] v;
      v = VEC[i];
      wr(2'd1, 32'd0);
      wr(2'd2, 32'd2);
      wr(2'd2, 32'd0);
      wr(2'd0, {18'd0, v[32:19]});
      exc(v[18:15]);
      check("R2 table cause", {18'd0, stop_reason}, {18'd0, v[14:1]});
      check("R3 table stall", {31'd0, cpu_stall}, {31'd0, v[0]});
    end

    // R2: loaded with mask bit 0 clears, other bits sticky
    wr(2'd2, 32'd2); wr(2'd2, 32'd0);
    wr(2'd1, 32'h0003);
    wr(2'd0, 32'h0000);
    exc(4'd1);
    check("R2 sticky load", {18'd0, stop_reason}, 32'h0001);

    // R10: same-cycle software write and exception
    wr(2'd0, 32'h0010);
    cfg_wr = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'h0000_2001;
    exc_valid = 1'b1; exc_class = 4'd4;
    step();
    cfg_wr = 1'b0; exc_valid = 1'b0;
    check("R10 write vs exception", {18'd0, stop_reason}, 32'h2011);

    // R6: ignore flag
    wr(2'd2, 32'd2); wr(2'd2, 32'd1);
    exc_valid = 1'b1; exc_class = 4'd12; #1;
    check("R6 break stepping", {31'd0, exc_ignore}, 32'd1);
    exc_class = 4'd13; #1;
    check("R6 trap stepping", {31'd0, exc_ignore}, 32'd0);
    step(); exc_valid = 1'b0;
    wr(2'd2, 32'd2); wr(2'd2, 32'd0);
    exc_valid = 1'b1; exc_class = 4'd12; #1;
    check("R6 break not stepping", {31'd0, exc_ignore}, 32'd0);
    step(); exc_valid = 1'b0;
    wr(2'd2, 32'd2); wr(2'd2, 32'd0);

    // R4: request edges
    ext_stall_req = 1'b1; step();
    check("R4 rise", {31'd0, cpu_stall}, 32'd1);
    step();
    check("R4 hold", {31'd0, cpu_stall}, 32'd1);
    ext_stall_req = 1'b0; step();
    check("R4 fall", {31'd0, cpu_stall}, 32'd0);

    // R5: disable overrides
    ext_stall_req = 1'b1; step();
    wr(2'd2, 32'd2);
    check("R5 disable drops stall", {31'd0, cpu_stall}, 32'd0);
    wr(2'd0, 32'h3FFF);
    exc(4'd3);
    check("R5 armed exception while disabled", {31'd0, cpu_stall}, 32'd0);
    check("R2 cause while disabled", {31'd0, stop_reason[3]}, 32'd1);
    wr(2'd2, 32'd0);
    check("R5 after enable", {31'd0, cpu_stall}, 32'd0);
    ext_stall_req = 1'b0; step();

    // R7: immediate issue while halted
    ext_stall_req = 1'b1; step();
    wr(2'd3, 32'hDEAD_BEEF);
    check("R7 valid", {31'd0, inj_valid}, 32'd1);
    check("R7 data", inj_data, 32'hDEAD_BEEF);
    step();
    check("R7 one cycle", {31'd0, inj_valid}, 32'd0);
    ext_stall_req = 1'b0; step();

    // R8: pending until the stall rises
    wr(2'd3, 32'h1234_5678);
    check("R8 held while running", {31'd0, inj_valid}, 32'd0);
    ext_stall_req = 1'b1; step();
    check("R8 stall", {31'd0, cpu_stall}, 32'd1);
    check("R8 valid on rise", {31'd0, inj_valid}, 32'd1);
    check("R8 data", inj_data, 32'h1234_5678);
    step();
    check("R8 pulse ends", {31'd0, inj_valid}, 32'd0);
    ext_stall_req = 1'b0; step();
    ext_stall_req = 1'b1; step();
    check("R8 no repeat", {31'd0, inj_valid}, 32'd0);

    // R7/R8: halted but in reset keeps the word pending
    core_in_reset = 1'b1;
    wr(2'd3, 32'hCAFE_0001);
    check("R7 in reset no issue", {31'd0, inj_valid}, 32'd0);
    core_in_reset = 1'b0;
    ext_stall_req = 1'b0; step();
    ext_stall_req = 1'b1; step();
    check("R8 issue after reset", {31'd0, inj_valid}, 32'd1);
    check("R8 data after reset", inj_data, 32'hCAFE_0001);
    ext_stall_req = 1'b0; step();

    // R9: read access
    rd_check("R9 inject read", 2'd3, 32'd0, 1'b1);
    rd_check("R9 mask read", 2'd0, 32'h3FFF, 1'b0);

    finish_run();
  end
endmodule